// File: doc/BRIEF.md
# ADC Sample Frame Serializer

This block turns parallel converter samples into a double-data-rate serial stream on one lane. Alongside the data it drives a frame clock that marks the start of each sample and a bit clock whose phase against the data can be programmed. Everything runs in one fast clock domain, where each serial bit lasts two ticks and one bit-clock period lasts four. That gives quarter-period steps for the bit-clock phase. A 12-bit sample fills a 24-tick frame: six bit-clock periods, with one bit on each edge.

Samples arrive with a valid strobe and are held until the next frame boundary, where serialization starts. If no new sample has arrived by then, the held word is sent again. Static configuration inputs choose the coding (offset binary, or two's complement by inverting the MSB), the bit order, a one-bit-clock slide of data and frame clock (later or earlier), and the bit-clock phase. All configuration is latched at the frame boundary.

Top module: `adc_frame_serializer`

## Requirements
- R1: While reset is held, serData, frameClk and bitClk are all 0.
- R2: frameClk is high for 12 ticks and then low for 12 ticks, repeating every 24 ticks. Its rising edge marks the first tick of the first bit of a frame.
- R3: Each bit occupies two consecutive ticks, aligned to an even tick of the frame. With cfgMsbFirst=0 the first bit after the frameClk rise is sample bit 0, and the bits follow in ascending order.
- R4: With cfgMsbFirst=1 the order reverses: bit 11 comes first and bit 0 last.
- R5: With cfgTwosComp=0 the sample is sent unchanged (offset binary). With cfgTwosComp=1 only the MSB (bit 11) is inverted before serialization.
- R6: With no slide, frameClk first rises at the output on the 5th clock edge after reset release. cfgDelay=1 alone moves data and frameClk 4 ticks later. cfgAdvance=1 alone moves them 4 ticks earlier. Setting both, or neither, gives no slide.
- R7: The slide controls never move bitClk: its waveform against the internal frame counter is the same in every slide setting.
- R8: bitClk has a 4-tick period and is high for 2 ticks. Counting ticks from a frame start of the unslid stream, it goes high at tick offset 3 - cfgPhase: 10 gives 1 (the reset setting, with edges at bit-window centres), 11 gives 0, 01 gives 2 and 00 gives 3.
- R9: A sample presented with sampleValid is captured and sent from the next frame boundary. Without a new sample, the previous one is repeated.
- R10: A configuration change takes effect only at the next frame boundary. Mid-frame changes do not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock, two ticks per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| sampleIn | input | 12 | Parallel converter sample |
| sampleValid | input | 1 | Captures sampleIn for the next frame |
| cfgTwosComp | input | 1 | 1 selects two's complement (MSB inverted) |
| cfgMsbFirst | input | 1 | 1 sends the MSB first |
| cfgDelay | input | 1 | Slide data and frame clock one bit-clock later |
| cfgAdvance | input | 1 | Slide data and frame clock one bit-clock earlier |
| cfgPhase | input | 2 | Bit-clock phase select |
| serData | output | 1 | Serial data, one bit per two ticks |
| frameClk | output | 1 | Frame clock at the sample rate |
| bitClk | output | 1 | DDR bit clock |

## Verification
Assertions check every cycle that the frame counter wraps after the boundary strobe, that latched configuration moves only at that strobe, that a valid sample is taken into the holding register, and that data and frame clock never change in the middle of a two-tick bit window. The ordering, the coding, the slide amounts, the phase offsets and the repetition of a held sample all depend on whole frames. Only the bench's behavioural model can show them, comparing every output on every tick and deserializing the lane for each of the 64 combinations of coding, order, slide and phase. The mid-frame configuration scenario is the only test of deferral to the boundary.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

  localparam int TICKS_PER_BIT    = 2;
  localparam int TICKS_PER_BITCLK = 2 * TICKS_PER_BIT;

  typedef struct packed {
    logic       twosComp;
    logic       msbFirst;
    logic       slideLate;
    logic       slideEarly;
    logic [1:0] phaseSel;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{
    twosComp:   1'b0,
    msbFirst:   1'b0,
    slideLate:  1'b0,
    slideEarly: 1'b0,
    phaseSel:   2'b10
  };

  // strobes from the frame control to the datapath
  typedef struct packed {
    logic       load;       // last tick of frame: take new word and config
    logic       bitStep;    // odd tick: move to the next bit
    logic       firstHalf;  // frame clock high phase
    logic [1:0] quarter;    // tick position inside a bit-clock period
  } strobe_t;

endpackage

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_ser_pkg::*;
#(
  parameter int SAMPLE_BITS = 12
) (
  input  logic    clk,
  input  logic    rst,
  output strobe_t strb
);

  localparam int FRAME_TICKS = SAMPLE_BITS * TICKS_PER_BIT;
  localparam int CNT_W       = $clog2(FRAME_TICKS);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(FRAME_TICKS - 1);
  localparam logic [CNT_W-1:0] HALF_TICK = CNT_W'(SAMPLE_BITS);

  logic [CNT_W-1:0] refCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      refCnt <= '0;
    end else if (refCnt == LAST_TICK) begin
      refCnt <= '0;
    end else begin
      refCnt <= refCnt + 1'b1;
    end
  end

  always_comb begin
    strb.load      = (refCnt == LAST_TICK);
    strb.bitStep   = refCnt[0];
    strb.firstHalf = (refCnt < HALF_TICK);
    strb.quarter   = refCnt[1:0];
  end

  // R2: a frame restarts right after its boundary strobe
  p_frame_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> (refCnt == '0))
    else $error("frame counter did not wrap after boundary");

endmodule

// File: rtl/adc_frame_datapath.sv
module adc_frame_datapath
  import adc_ser_pkg::*;
#(
  parameter int SAMPLE_BITS = 12,
  parameter int SLIDE_TICKS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  strobe_t                strb,
  input  logic [SAMPLE_BITS-1:0] sampleIn,
  input  logic                   sampleValid,
  input  cfg_t                   cfgIn,
  output logic                   serData,
  output logic                   frameClk,
  output logic                   bitClk
);

  localparam int LINE_DEPTH = 2 * SLIDE_TICKS;
  localparam int MSB        = SAMPLE_BITS - 1;

  logic [SAMPLE_BITS-1:0] holdQ;
  logic [SAMPLE_BITS-1:0] shiftQ;
  cfg_t                   cfgQ;

  function automatic logic [SAMPLE_BITS-1:0] formatWord(
    input logic [SAMPLE_BITS-1:0] raw,
    input cfg_t                   c
  );
    logic [SAMPLE_BITS-1:0] coded;
    logic [SAMPLE_BITS-1:0] ordered;
    coded      = raw;
    coded[MSB] = raw[MSB] ^ c.twosComp;
    for (int i = 0; i < SAMPLE_BITS; i++) begin
      ordered[i] = c.msbFirst ? coded[MSB - i] : coded[i];
    end
    return ordered;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      holdQ  <= '0;
      shiftQ <= '0;
      cfgQ   <= CFG_RESET;
    end else begin
      if (sampleValid) begin
        holdQ <= sampleIn;
      end
      if (strb.load) begin
        shiftQ <= formatWord(holdQ, cfgIn);
        cfgQ   <= cfgIn;
      end else if (strb.bitStep) begin
        shiftQ <= shiftQ >> 1;
      end
    end
  end

  // unslid-early stream: {data, frame clock}
  logic [1:0] baseSym;
  assign baseSym = {shiftQ[0], strb.firstHalf};

  logic [1:0] lineQ [LINE_DEPTH];

  generate
    for (genvar s = 0; s < LINE_DEPTH; s++) begin : g_line
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) lineQ[s] <= '0;
          else     lineQ[s] <= baseSym;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst) lineQ[s] <= '0;
          else     lineQ[s] <= lineQ[s-1];
        end
      end
    end
  endgenerate

  logic [1:0] tapSym;
  always_comb begin
    if (cfgQ.slideEarly && !cfgQ.slideLate) begin
      tapSym = baseSym;
    end else if (cfgQ.slideLate && !cfgQ.slideEarly) begin
      tapSym = lineQ[LINE_DEPTH-1];
    end else begin
      tapSym = lineQ[SLIDE_TICKS-1];
    end
  end

  logic [1:0] phaseOff;
  logic [1:0] relQuarter;
  assign phaseOff   = ~cfgQ.phaseSel;
  assign relQuarter = strb.quarter - phaseOff;

  always_ff @(posedge clk) begin
    if (rst) begin
      serData  <= 1'b0;
      frameClk <= 1'b0;
      bitClk   <= 1'b0;
    end else begin
      serData  <= tapSym[1];
      frameClk <= tapSym[0];
      bitClk   <= ~relQuarter[1];
    end
  end

  // R10: latched configuration moves only at the frame boundary
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> $stable(cfgQ))
    else $error("configuration changed mid-frame");

  // R9: a valid sample is taken into the holding register
  p_capture_r9: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> (holdQ == $past(sampleIn)))
    else $error("sample not captured");

  // R3: data and frame clock hold for the second tick of each bit window
  p_bit_window_r3: assert property (@(posedge clk) disable iff (rst)
    strb.bitStep |=> ($stable(serData) && $stable(frameClk)))
    else $error("output changed inside a bit window");

endmodule

// File: rtl/adc_frame_serializer.sv
module adc_frame_serializer
  import adc_ser_pkg::*;
#(
  parameter int SAMPLE_BITS = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SAMPLE_BITS-1:0] sampleIn,
  input  logic                   sampleValid,
  input  logic                   cfgTwosComp,
  input  logic                   cfgMsbFirst,
  input  logic                   cfgDelay,
  input  logic                   cfgAdvance,
  input  logic [1:0]             cfgPhase,
  output logic                   serData,
  output logic                   frameClk,
  output logic                   bitClk
);

  localparam int SLIDE_TICKS = TICKS_PER_BITCLK;

  strobe_t strb;
  cfg_t    cfgIn;

  assign cfgIn = '{
    twosComp:   cfgTwosComp,
    msbFirst:   cfgMsbFirst,
    slideLate:  cfgDelay,
    slideEarly: cfgAdvance,
    phaseSel:   cfgPhase
  };

  adc_frame_ctrl #(
    .SAMPLE_BITS(SAMPLE_BITS)
  ) i_ctrl (
    .clk (clk),
    .rst (rst),
    .strb(strb)
  );

  adc_frame_datapath #(
    .SAMPLE_BITS(SAMPLE_BITS),
    .SLIDE_TICKS(SLIDE_TICKS)
  ) i_datapath (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .sampleIn   (sampleIn),
    .sampleValid(sampleValid),
    .cfgIn      (cfgIn),
    .serData    (serData),
    .frameClk   (frameClk),
    .bitClk     (bitClk)
  );

endmodule

// File: tb/test_adc_frame_serializer.sv
`timescale 1ns/1ps
module test_adc_frame_serializer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] sampleIn = '0;
  logic        sampleValid = 1'b0;
  logic        cfgTwosComp = 1'b0;
  logic        cfgMsbFirst = 1'b0;
  logic        cfgDelay = 1'b0;
  logic        cfgAdvance = 1'b0;
  logic [1:0]  cfgPhase = 2'b10;
  logic        serData, frameClk, bitClk;

  always #5 clk = ~clk;

  adc_frame_serializer i_adc_frame_serializer (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .cfgTwosComp(cfgTwosComp), .cfgMsbFirst(cfgMsbFirst),
    .cfgDelay(cfgDelay), .cfgAdvance(cfgAdvance), .cfgPhase(cfgPhase),
    .serData(serData), .frameClk(frameClk), .bitClk(bitClk)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mRef, mLastR, mPh;
  logic [11:0] mHold, mWord;
  bit mDl, mAd, modelOn;
  bit eData, eF, eL;
  logic [1:0] hist[$];

  function automatic logic [11:0] txOrder(input logic [11:0] w, input bit tc, input bit mf);
    logic [11:0] c = w;
    logic [11:0] o;
    if (tc) c[11] = ~c[11];
    for (int k = 0; k < 12; k++) o[k] = mf ? c[11-k] : c[k];
    return o;
  endfunction

  function automatic bit lclkAt(input int r, input int ph);
    int p = 3 - ph;
    return ((((r - p) % 4) + 4) % 4) < 2;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mRef = 0; mHold = '0; mWord = '0; mDl = 0; mAd = 0; mPh = 2;
      hist.delete(); modelOn = 0; mLastR = 0;
    end else begin
      int r, idx;
      logic [1:0] v;
      r = mRef;
      hist.push_front({mWord[r/2], (r < 12) ? 1'b1 : 1'b0});
      if (hist.size() > 9) void'(hist.pop_back());
      idx = (mDl && !mAd) ? 8 : ((mAd && !mDl) ? 0 : 4);
      v = (hist.size() > idx) ? hist[idx] : 2'b00;
      eData = v[1]; eF = v[0]; eL = lclkAt(r, mPh);
      mLastR = r;
      if (r == 23) begin
        mWord = txOrder(mHold, cfgTwosComp, cfgMsbFirst);
        mDl = cfgDelay; mAd = cfgAdvance; mPh = int'(cfgPhase);
      end
      if (sampleValid) mHold = sampleIn;
      mRef = (r + 1) % 24;
      modelOn = 1;
    end
  end

  // ---------------- per-tick compare and deserializer ----------------
  bit prevF = 0, collecting = 0;
  int col = 0, highCnt = 0, desCount = 0, desRiseR = 0, riseR = 0, desHigh = 0;
  logic [11:0] raw, desWord;
  logic [3:0] pat, desPat, refPat;

  always @(negedge clk) begin
    if (modelOn && !rst && !done) begin
      chk(serData == eData, "R3 data", serData, eData);
      chk(frameClk == eF, "R2 frameClk", frameClk, eF);
      chk(bitClk == eL, "R8 bitClk", bitClk, eL);
      if (mLastR < 4) refPat[mLastR] = bitClk;
      if (frameClk && !prevF) begin
        collecting = 1; col = 0; highCnt = 0; riseR = mLastR;
      end
      if (collecting) begin
        if (col % 2 == 0) raw[col/2] = serData;
        if (col < 4) pat[col] = bitClk;
        if (frameClk) highCnt++;
        col++;
        if (col == 24) begin
          desWord = raw; desPat = pat; desHigh = highCnt; desRiseR = riseR;
          desCount++; collecting = 0;
        end
      end
      prevF = frameClk;
    end
  end

  // ---------------- scenarios ----------------
  task automatic waitTicks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runCombo(input bit tc, input bit mf, input bit dl, input bit ad,
                          input int ph, input logic [11:0] s);
    logic [11:0] dec, first;
    logic [3:0] expPat;
    int expRise;
    @(negedge clk);
    cfgTwosComp = tc; cfgMsbFirst = mf; cfgDelay = dl; cfgAdvance = ad;
    cfgPhase = 2'(ph); sampleIn = s; sampleValid = 1;
    @(negedge clk);
    sampleValid = 0; sampleIn = ~s;
    waitTicks(110);
    for (int k = 0; k < 12; k++) dec[k] = mf ? desWord[11-k] : desWord[k];
    if (tc) dec[11] = ~dec[11];
    if (tc)      chk(dec == s, "R5 coding", dec, s);
    else if (mf) chk(dec == s, "R4 msb-first order", dec, s);
    else         chk(dec == s, "R3 lsb-first order", dec, s);
    chk(desHigh == 12, "R2 frame high ticks", desHigh, 12);
    expRise = (dl && !ad) ? 8 : ((ad && !dl) ? 0 : 4);
    chk(desRiseR == expRise, "R6 slide", desRiseR, expRise);
    for (int j = 0; j < 4; j++) expPat[j] = lclkAt(j, ph);
    chk(refPat == expPat, "R7 bitClk fixed", refPat, expPat);
    chk(desPat == expPat, "R8 phase", desPat, expPat);
    first = desWord;
    waitTicks(48);
    chk(desWord == first, "R9 repeat", desWord, first);
  endtask

  initial begin
    repeat (4) begin
      @(negedge clk);
      chk({serData, frameClk, bitClk} == 3'b000, "R1 reset", {serData, frameClk, bitClk}, 0);
    end
    rst = 0;

    // first frame after reset carries the reset word 0; then default settings
    runCombo(0, 0, 0, 0, 2, 12'hA5C);

    // R10: a slide requested mid-frame waits for the boundary
    while (mLastR != 9) @(negedge clk);
    cfgDelay = 1;
    while (mLastR != 16) @(negedge clk);
    chk(frameClk == 1'b0, "R10 mid-frame change deferred", frameClk, 0);
    @(negedge clk);
    while (mLastR != 16) @(negedge clk);
    chk(frameClk == 1'b1, "R10 change applied at boundary", frameClk, 1);
    cfgDelay = 0;

    for (int tc = 0; tc < 2; tc++)
      for (int mf = 0; mf < 2; mf++)
        for (int sh = 0; sh < 4; sh++)
          for (int ph = 0; ph < 4; ph++)
            runCombo(tc[0], mf[0], sh[0], sh[1], ph,
                     12'((tc * 1931 + mf * 733 + sh * 211 + ph * 97 + 45) & 12'hFFF));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog R1 actual=%0h expected=%0h", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule